// File: doc/BRIEF.md
# SPI Channel Transfer Sequencer

This block is the control engine for one channel of a multichannel SPI master. It holds the channel's configuration, enable bit, transmit holding word and received word. From these and three status flags it decides, every idle cycle, whether the next word may be shifted. Once a shift starts, a built-in shifter moves the programmed number of bits most significant bit first, one bit per clock. When the shift ends, the block sets the end-of-transfer, TX-empty and RX-full flags as the transfer mode requires.

The same state drives two DMA request lines. When an external FIFO is in use, these lines also obey fill-level thresholds. A 16-bit word counter is shared with the FIFO path and produces a one-cycle end-of-word pulse when it runs out. Register writes and reads reach the block as one-cycle strobes from the surrounding register file. The FIFO storage and its fill counters live outside the block.

Top module: `spi_chan_seq`

## Requirements
- R1: The transfer mode is config bits 13:12. Value 0 is full duplex, 1 is receive-only, 2 is transmit-only and 3 is invalid. In receive-only mode a shift starts without any TX data having been written, and it sends zeros.
- R2: No shift starts while the channel enable is 0. Once the enable is set, an allowed shift starts on the next clock edge.
- R3: While RX-full (status bit 0) is set and the mode is not transmit-only, no shift starts. Turbo (config bit 19) lifts this stall.
- R4: While TX-empty (status bit 1) is set and the mode is not receive-only, no shift starts.
- R5: When a shift completes, end-of-transfer (status bit 2) and TX-empty are set, and the TX holding word becomes 0. RX-full is set, except in transmit-only mode, where it is cleared.
- R6: A TX data write loads the holding word and clears end-of-transfer and TX-empty. An RX read strobe clears RX-full.
- R7: The word length is config bits 11:7 plus one. The shift sends the holding word MSB first on `mosi` and collects `miso` MSB first. Only the low word-length bits of `rx_data` carry the result, and the bits above them are 0.
- R8: `tx_dreq` is high when the channel is enabled, config bit 14 is set, TX-empty is set and the mode is not receive-only. When the TX FIFO is enabled (config bit 27), it also requires `tx_fill` to be at or below the almost-empty threshold.
- R9: `rx_dreq` is high when the channel is enabled, config bit 15 is set, RX-full is set and the mode is not transmit-only. When the RX FIFO is enabled (config bit 28), it also requires `rx_fill` to be at or above the almost-full threshold.
- R10: After reset, the config is 0x060000, the status is 3'b010 and the channel is idle and disabled.
- R11: A level write loads the 16-bit word counter. Each completed shift decrements it while either FIFO is enabled. `eow` pulses for one cycle when the counter reaches 0, provided the loaded value was nonzero.
- R12: `busy` rises on the edge after the start condition holds and stays high for exactly word-length cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_wdata | input | 30 | Config write value |
| cfg_q | output | 30 | Current config |
| en_we | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable value |
| lvl_we | input | 1 | Level write strobe |
| lvl_ae | input | THR_W | Almost-empty threshold |
| lvl_af | input | THR_W | Almost-full threshold |
| lvl_cnt | input | 16 | Word count to load |
| tx_we | input | 1 | TX data write strobe |
| tx_wdata | input | 32 | TX data |
| rx_re | input | 1 | RX read strobe |
| rx_data | output | 32 | Last received word |
| tx_hold_q | output | 32 | TX holding word |
| tx_fill | input | FILL_W | TX FIFO fill level |
| rx_fill | input | FILL_W | RX FIFO fill level |
| miso | input | 1 | Serial input |
| mosi | output | 1 | Serial output |
| busy | output | 1 | Shift in progress |
| status | output | 3 | {end-of-transfer, TX-empty, RX-full} |
| tx_dreq | output | 1 | TX DMA request |
| rx_dreq | output | 1 | RX DMA request |
| wcnt_q | output | 16 | Word counter |
| eow | output | 1 | End-of-word pulse |

## Verification
The assertions assume that the register file never sends a TX write or an RX read in the same cycle a shift completes. They also assume that the config does not change on that edge, because the write would then overwrite the completion flags they inspect. The bench issues every strobe only after it has seen `busy` fall. It changes the mode only while the start condition is false, or when it expects the change to launch a shift that it then drives to completion. The word-length field is never programmed below 3.

// File: rtl/spi_chan_seq.sv
module spi_chan_seq #(
  parameter int THR_W  = 6,
  parameter int FILL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [29:0]       cfg_wdata,
  output logic [29:0]       cfg_q,
  input  logic              en_we,
  input  logic              en_wdata,
  input  logic              lvl_we,
  input  logic [THR_W-1:0]  lvl_ae,
  input  logic [THR_W-1:0]  lvl_af,
  input  logic [15:0]       lvl_cnt,
  input  logic              tx_we,
  input  logic [31:0]       tx_wdata,
  input  logic              rx_re,
  output logic [31:0]       rx_data,
  output logic [31:0]       tx_hold_q,
  input  logic [FILL_W-1:0] tx_fill,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic              miso,
  output logic              mosi,
  output logic              busy,
  output logic [2:0]        status,
  output logic              tx_dreq,
  output logic              rx_dreq,
  output logic [15:0]       wcnt_q,
  output logic              eow
);
  localparam logic [29:0] CFG_RST = 30'h0060000;
  localparam logic [1:0]  M_RXO = 2'd1;
  localparam logic [1:0]  M_TXO = 2'd2;

  logic              en, rxf, txe, eot;
  logic [THR_W-1:0]  ae_thr, af_thr;
  logic [15:0]       wtot;
  logic [31:0]       sh;
  logic [30:0]       rsh;
  logic [4:0]        cnt;

  wire [1:0] mode  = cfg_q[13:12];
  wire       turbo = cfg_q[19];
  wire       fifo  = cfg_q[27] | cfg_q[28];
  wire [5:0] wl    = {1'b0, cfg_q[11:7]} + 6'd1;
  wire [5:0] sft   = 6'd32 - wl;
  wire       done  = busy && (cnt == 5'd0);

  wire rx_stall = rxf && (mode != M_TXO) && !turbo;
  wire tx_stall = txe && (mode != M_RXO);
  wire start    = en && !busy && !rx_stall && !tx_stall;

  assign status = {eot, txe, rxf};
  assign mosi   = busy & sh[31];

  assign tx_dreq = en && cfg_q[14] && txe && (mode != M_RXO) &&
                   (!cfg_q[27] || tx_fill <= FILL_W'(ae_thr));
  assign rx_dreq = en && cfg_q[15] && rxf && (mode != M_TXO) &&
                   (!cfg_q[28] || rx_fill >= FILL_W'(af_thr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RST;
      en        <= 1'b0;
      rxf       <= 1'b0;
      txe       <= 1'b1;
      eot       <= 1'b0;
      busy      <= 1'b0;
      sh        <= '0;
      rsh       <= '0;
      cnt       <= '0;
      rx_data   <= '0;
      tx_hold_q <= '0;
      ae_thr    <= '0;
      af_thr    <= '0;
      wcnt_q    <= '0;
      wtot      <= '0;
      eow       <= 1'b0;
    end else begin
      eow <= 1'b0;
      if (cfg_we) cfg_q <= cfg_wdata;
      if (en_we)  en    <= en_wdata;

      if (start) begin
        busy <= 1'b1;
        sh   <= tx_hold_q << sft;
        cnt  <= cfg_q[11:7];
      end

      if (busy) begin
        rsh <= {rsh[29:0], miso};
        sh  <= sh << 1;
        cnt <= cnt - 5'd1;
      end

      if (done) begin
        busy      <= 1'b0;
        rx_data   <= {rsh, miso} & (32'hFFFF_FFFF >> sft);
        eot       <= 1'b1;
        txe       <= 1'b1;
        rxf       <= (mode != M_TXO);
        tx_hold_q <= '0;
        if (fifo) begin
          wcnt_q <= wcnt_q - 16'd1;
          eow    <= (wcnt_q == 16'd1) && (wtot != 16'd0);
        end
      end

      if (tx_we) begin
        tx_hold_q <= tx_wdata;
        eot       <= 1'b0;
        txe       <= 1'b0;
      end

      if (rx_re) rxf <= 1'b0;

      if (lvl_we) begin
        ae_thr <= lvl_ae;
        af_thr <= lvl_af;
        wcnt_q <= lvl_cnt;
        wtot   <= lvl_cnt;
        eow    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_chan_seq_chk.sv
module spi_chan_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        busy,
  input logic [2:0]  status,
  input logic [29:0] cfg_q,
  input logic        tx_we,
  input logic        rx_re,
  input logic        tx_dreq,
  input logic        rx_dreq,
  input logic        eow,
  input logic [15:0] wcnt_q
);
  AST_NO_RUN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> !busy); // R2
  AST_RXFULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && status[0] && cfg_q[13:12] != 2'd2 && !cfg_q[19]) |=> !busy); // R3
  AST_TXEMPTY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && status[1] && cfg_q[13:12] != 2'd1) |=> !busy); // R4
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(tx_we)) |-> (status[2] && status[1])); // R5
  AST_DONE_RXFULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(rx_re) && $stable(cfg_q)) |-> (status[0] == (cfg_q[13:12] != 2'd2))); // R5
  AST_TX_DREQ_COND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq |-> (en && cfg_q[14] && status[1] && cfg_q[13:12] != 2'd1)); // R8
  AST_RX_DREQ_COND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dreq |-> (en && cfg_q[15] && status[0] && cfg_q[13:12] != 2'd2)); // R9
  AST_EOW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    eow |-> (wcnt_q == 16'd0)); // R11
endmodule

bind spi_chan_seq spi_chan_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .busy(busy), .status(status),
  .cfg_q(cfg_q), .tx_we(tx_we), .rx_re(rx_re), .tx_dreq(tx_dreq),
  .rx_dreq(rx_dreq), .eow(eow), .wcnt_q(wcnt_q)
);

// File: tb/spi_chan_seq_test.sv
`timescale 1ns/1ps
module spi_chan_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, en_we = 0, en_wdata = 0, lvl_we = 0, tx_we = 0, rx_re = 0, miso = 0;
  logic [29:0] cfg_wdata = '0;
  logic [5:0]  lvl_ae = '0, lvl_af = '0;
  logic [15:0] lvl_cnt = '0;
  logic [31:0] tx_wdata = '0;
  logic [6:0]  tx_fill = '0, rx_fill = '0;
  logic [29:0] cfg_q;
  logic [31:0] rx_data, tx_hold_q;
  logic        mosi, busy, tx_dreq, rx_dreq, eow;
  logic [2:0]  status;
  logic [15:0] wcnt_q;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  spi_chan_seq uut (.*);

  // {mode[1:0], wl_field[4:0], tx[31:0], miso pattern[31:0]}
  localparam logic [70:0] VEC [0:5] = '{
    {2'd0, 5'd7,  32'h0000_00A5, 32'h0000_003C},
    {2'd0, 5'd15, 32'h0000_1234, 32'h0000_BEEF},
    {2'd2, 5'd31, 32'hDEAD_BEEF, 32'h1357_9BDF},
    {2'd0, 5'd31, 32'h8000_0001, 32'hCAFE_F00D},
    {2'd2, 5'd3,  32'h0000_0009, 32'h0000_0006},
    {2'd0, 5'd11, 32'h0000_0ABC, 32'h0000_05A5}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [29:0] mkcfg(input logic [1:0] m, input logic [4:0] w,
      input logic tb, input logic td, input logic rd, input logic tf, input logic rf);
    logic [29:0] c = 30'h0060000;
    c[13:12] = m; c[11:7] = w; c[19] = tb; c[14] = td; c[15] = rd; c[27] = tf; c[28] = rf;
    return c;
  endfunction

  task automatic wr_cfg(input logic [29:0] v);
    cfg_we = 1; cfg_wdata = v; @(negedge clk); cfg_we = 0;
  endtask
  task automatic wr_en(input logic b);
    en_we = 1; en_wdata = b; @(negedge clk); en_we = 0;
  endtask
  task automatic wr_tx(input logic [31:0] v);
    tx_we = 1; tx_wdata = v; @(negedge clk); tx_we = 0;
  endtask
  task automatic rd_rx();
    rx_re = 1; @(negedge clk); rx_re = 0;
  endtask
  task automatic wr_lvl(input logic [5:0] a, input logic [5:0] f, input logic [15:0] c);
    lvl_we = 1; lvl_ae = a; lvl_af = f; lvl_cnt = c; @(negedge clk); lvl_we = 0;
  endtask

  task automatic shift(input logic [31:0] pat, input int wl, output logic [31:0] mo);
    int t = 0;
    mo = '0;
    while (!busy && t < 20) begin @(negedge clk); t++; end
    chk("R12 shift started", {31'b0, busy}, 32'd1);
    for (int i = wl - 1; i >= 0; i--) begin
      miso = pat[i];
      mo[i] = mosi;
      if (!busy) begin
        chk("R12 busy held for word length", 32'd0, 32'd1);
        break;
      end
      @(negedge clk);
    end
    chk("R12 busy falls after word length", {31'b0, busy}, 32'd0);
  endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] mo, msk;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 config", {2'b0, cfg_q}, 32'h0006_0000);
    chk("R10 status", {29'b0, status}, 32'd2);
    chk("R10 busy", {31'b0, busy}, 32'd0);
    chk("R10 dreq", {30'b0, tx_dreq, rx_dreq}, 32'd0);

    // R2: disabled channel does not start
    wr_cfg(mkcfg(2'd0, 5'd7, 0, 0, 0, 0, 0));
    wr_tx(32'h5A);
    chk("R6 tx write clears eot/txe", {29'b0, status}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      chk("R2 no start while disabled", {31'b0, busy}, 32'd0);
      @(negedge clk);
    end
    wr_en(1);
    chk("R12 not yet busy", {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk("R2 start after enable", {31'b0, busy}, 32'd1);
    shift(32'hC3, 8, mo);
    chk("R7 mosi msb first", mo, 32'h5A);
    chk("R7 rx data", rx_data, 32'hC3);
    chk("R5 completion flags", {29'b0, status}, 32'd7);
    chk("R5 tx hold zeroed", tx_hold_q, 32'd0);

    // R3: RX-full stalls, turbo releases
    wr_tx(32'h11);
    chk("R6 status after tx write", {29'b0, status}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      chk("R3 stall on rx full", {31'b0, busy}, 32'd0);
      @(negedge clk);
    end
    wr_cfg(mkcfg(2'd0, 5'd7, 1, 0, 0, 0, 0));
    shift(32'h0F, 8, mo);
    chk("R3 turbo transfer data", rx_data, 32'h0F);
    chk("R3 turbo mosi", mo, 32'h11);
    wr_cfg(mkcfg(2'd0, 5'd7, 0, 0, 0, 0, 0));

    // R4: TX-empty stalls
    rd_rx();
    chk("R6 rx read clears rx full", {29'b0, status}, 32'd6);
    for (int i = 0; i < 4; i++) begin
      chk("R4 stall on tx empty", {31'b0, busy}, 32'd0);
      @(negedge clk);
    end

    // R1: receive-only
    wr_cfg(mkcfg(2'd1, 5'd3, 0, 0, 0, 0, 0));
    shift(32'hA, 4, mo);
    chk("R1 rx-only sends zeros", mo, 32'd0);
    chk("R1 rx-only data", rx_data, 32'hA);
    chk("R1 rx-only flags", {29'b0, status}, 32'd7);
    for (int i = 0; i < 3; i++) begin
      chk("R1 rx-only stalls on rx full", {31'b0, busy}, 32'd0);
      @(negedge clk);
    end
    rd_rx();
    shift(32'h5, 4, mo);
    chk("R1 rx-only restarts after read", rx_data, 32'h5);
    wr_cfg(mkcfg(2'd0, 5'd7, 0, 0, 0, 0, 0));
    rd_rx();

    // R7 / R5 table walk
    for (int v = 0; v < 6; v++) begin
      logic [1:0] m; logic [4:0] w; logic [31:0] tx, pat;
      {m, w, tx, pat} = VEC[v];
      msk = 32'hFFFF_FFFF >> (31 - w);
      wr_cfg(mkcfg(m, w, 0, 0, 0, 0, 0));
      wr_tx(tx);
      shift(pat, int'(w) + 1, mo);
      chk("R7 table mosi", mo, tx & msk);
      if (m == 2'd0) chk("R7 table rx data", rx_data, pat & msk);
      chk("R5 table flags", {29'b0, status}, {29'b0, 2'b11, (m != 2'd2)});
      chk("R5 table tx hold", tx_hold_q, 32'd0);
      rd_rx();
    end

    // R8 / R9: DMA requests
    wr_cfg(mkcfg(2'd0, 5'd7, 0, 1, 0, 0, 0));
    chk("R8 tx dreq on tx empty", {31'b0, tx_dreq}, 32'd1);
    wr_cfg(mkcfg(2'd1, 5'd7, 0, 1, 0, 0, 0));
    chk("R8 tx dreq off in rx-only", {31'b0, tx_dreq}, 32'd0);
    shift(32'h00, 8, mo);
    wr_cfg(mkcfg(2'd0, 5'd7, 0, 0, 1, 0, 0));
    chk("R9 rx dreq on rx full", {31'b0, rx_dreq}, 32'd1);
    chk("R8 tx dreq off when disabled by config", {31'b0, tx_dreq}, 32'd0);
    wr_lvl(6'd4, 6'd10, 16'd0);
    wr_cfg(mkcfg(2'd0, 5'd7, 0, 1, 1, 1, 1));
    tx_fill = 7'd5; rx_fill = 7'd9; #1;
    chk("R8 tx dreq above threshold", {31'b0, tx_dreq}, 32'd0);
    chk("R9 rx dreq below threshold", {31'b0, rx_dreq}, 32'd0);
    tx_fill = 7'd4; rx_fill = 7'd10; #1;
    chk("R8 tx dreq at threshold", {31'b0, tx_dreq}, 32'd1);
    chk("R9 rx dreq at threshold", {31'b0, rx_dreq}, 32'd1);
    @(negedge clk);

    // R11: word counter
    rd_rx();
    wr_lvl(6'd4, 6'd10, 16'd2);
    chk("R11 counter loaded", {16'b0, wcnt_q}, 32'd2);
    wr_tx(32'h33);
    shift(32'h44, 8, mo);
    chk("R11 counter after first", {16'b0, wcnt_q}, 32'd1);
    chk("R11 no eow yet", {31'b0, eow}, 32'd0);
    rd_rx();
    wr_tx(32'h55);
    shift(32'h66, 8, mo);
    chk("R11 counter at zero", {16'b0, wcnt_q}, 32'd0);
    chk("R11 eow pulse", {31'b0, eow}, 32'd1);
    @(negedge clk);
    chk("R11 eow one cycle", {31'b0, eow}, 32'd0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule